// File: doc/BRIEF.md
# Performance-State Transition Sequencer

This block moves the shared clock-and-supply operating point of a multi-core cluster to a level that software asks for. Software writes a 16-bit control word whose low byte names a frequency ratio. The block clamps that ratio into the supported range and derives the matching supply code from a small built-in table. It then steps the external regulator and the clock generator in a safe order. The order depends on direction. Going faster, the supply rises first. Going slower, the clock drops first. A single request governs every core at once; there is no per-core setting.

Each step waits for the outside part to confirm. A rising edge of `vr_ready` confirms the regulator, and a rising edge of `pll_lock` confirms the clock generator. A separate status word reports the point in effect. It changes only once the whole sequence has finished. A request written while a transition is under way waits in a one-deep holding slot. A newer write replaces the held one. The held request starts as soon as the current sequence finishes.

The controller has six named states:
- `S_IDLE`: waiting.
- `S_RAISE_V`: the supply code has been raised; waiting for the regulator.
- `S_RAISE_F`: the ratio has been raised; waiting for lock.
- `S_LOWER_F`: the ratio has been lowered; waiting for lock.
- `S_LOWER_V`: the supply code has been lowered; waiting for the regulator.
- `S_COMMIT`: the status word is written.

The transitions are:
- `S_IDLE`→`S_RAISE_V` when a held ratio is above the applied one.
- `S_IDLE`→`S_LOWER_F` when a held ratio is below it.
- `S_RAISE_V`→`S_RAISE_F` on a regulator rise.
- `S_RAISE_F`→`S_COMMIT` on a lock rise.
- `S_LOWER_F`→`S_LOWER_V` on a lock rise.
- `S_LOWER_V`→`S_COMMIT` on a regulator rise.
- `S_COMMIT`→`S_IDLE` unconditionally.

Top module: `pstate_seq`

## Requirements
- R1: After reset, `ratio_out` is 1, `vid_out` is 43 (0x2B), `stat_out` is 0x2B01 and `busy` is 0.
- R2: A write takes the requested ratio from `req_data[7:0]`; `req_data[15:8]` has no effect on the result.
- R3: A requested ratio below 1 is treated as 1, and one above 39 is treated as 39; `ratio_out` never leaves 1..39.
- R4: The supply code for ratio r is 40 + 3·r, and the code that is applied always belongs to the applied ratio.
- R5: When the ratio rises, `vid_out` changes first. The sequencer waits for a 0→1 edge of `vr_ready`, then changes `ratio_out`, then waits for a 0→1 edge of `pll_lock`.
- R6: When the ratio falls, `ratio_out` changes first. The sequencer waits for a 0→1 edge of `pll_lock`, then lowers `vid_out`, then waits for a 0→1 edge of `vr_ready`.
- R7: `stat_out` = {supply code in bits 15:8, ratio in bits 7:0}. It is updated one cycle after the last confirming edge, never before both confirmations are seen, and at no other time.
- R8: A write made while `busy` is 1 is held, and a later write replaces it. The newest held request starts after the current transition commits. This includes a write that lands in the same cycle as the final confirmation.
- R9: A request equal to the applied ratio starts no transition: `busy` stays 0 and the outputs hold.
- R10: `vid_out` and `ratio_out` never change in the same cycle, and neither changes while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Control-word write strobe |
| req_data | input | 16 | Control word; bits 7:0 give the requested ratio |
| vr_ready | input | 1 | Regulator settled level; a rising edge confirms a supply change |
| pll_lock | input | 1 | Clock-generator lock level; a rising edge confirms a ratio change |
| vid_out | output | 8 | Supply code sent to the regulator |
| ratio_out | output | 8 | Frequency ratio sent to the clock generator |
| stat_out | output | 16 | Applied point: supply code in bits 15:8, ratio in bits 7:0 |
| busy | output | 1 | High while a transition is in progress |

## Verification
Two events can fall in the same cycle: a new control write arrives, and the final confirming edge moves the sequencer into `S_COMMIT`. The bench provokes this by watching `pll_lock` during an upward step and asserting the write strobe on the exact cycle the lock edge is sampled. The scoreboard then demands both status values, in order: the finishing point first, then the newly requested one. On every ratio or code change, a monitor also checks that the direction-dependent ordering holds.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RAISE_V,
        S_RAISE_F,
        S_LOWER_F,
        S_LOWER_V,
        S_COMMIT
    } seq_state_t;

endpackage

// File: rtl/pstate_vid_lut.sv
module pstate_vid_lut #(
    parameter int RW        = 8,
    parameter int VW        = 8,
    parameter int RATIO_MIN = 1,
    parameter int RATIO_MAX = 39,
    parameter int VID_BASE  = 40,
    parameter int VID_STEP  = 3
) (
    input  logic [RW-1:0] ratio,
    output logic [VW-1:0] vid
);
    localparam int N  = RATIO_MAX + 1;
    localparam int IW = $clog2(N);

    logic [VW-1:0] tbl [N];
    logic [IW-1:0] idx;

    for (genvar i = 0; i < N; i++) begin : g_entry
        localparam int EFF = (i < RATIO_MIN) ? RATIO_MIN : i;
        assign tbl[i] = VW'(VID_BASE + VID_STEP * EFF);
    end

    assign idx = (int'(ratio) > RATIO_MAX) ? IW'(RATIO_MAX) : ratio[IW-1:0];
    assign vid = tbl[idx];
endmodule

// File: rtl/pstate_req_hold.sv
module pstate_req_hold #(
    parameter int CW        = 16,
    parameter int RW        = 8,
    parameter int RATIO_MIN = 1,
    parameter int RATIO_MAX = 39
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] data,
    input  logic          take,
    output logic          valid,
    output logic [RW-1:0] ratio
);
    logic [RW-1:0] raw;
    logic [RW-1:0] clamped;
    logic          unused_hi;

    assign raw       = data[RW-1:0];
    assign unused_hi = ^data[CW-1:RW];

    always_comb begin
        if (int'(raw) < RATIO_MIN)      clamped = RW'(RATIO_MIN);
        else if (int'(raw) > RATIO_MAX) clamped = RW'(RATIO_MAX);
        else                            clamped = raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            ratio <= RW'(RATIO_MIN);
        end else if (wr) begin
            valid <= 1'b1;
            ratio <= clamped;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pstate_rise.sv
module pstate_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pstate_seq.sv
module pstate_seq
    import pstate_pkg::*;
#(
    parameter int CW        = 16,
    parameter int RW        = 8,
    parameter int VW        = 8,
    parameter int RATIO_MIN = 1,
    parameter int RATIO_MAX = 39,
    parameter int VID_BASE  = 40,
    parameter int VID_STEP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic [CW-1:0]    req_data,
    input  logic             vr_ready,
    input  logic             pll_lock,
    output logic [VW-1:0]    vid_out,
    output logic [RW-1:0]    ratio_out,
    output logic [VW+RW-1:0] stat_out,
    output logic             busy
);
    localparam logic [VW-1:0] VID_RST = VW'(VID_BASE + VID_STEP * RATIO_MIN);

    seq_state_t    state, state_nx;
    logic          pend_valid, take, start, go_up;
    logic [RW-1:0] pend_ratio, tgt, lut_idx;
    logic [VW-1:0] lut_vid;
    logic          vr_rise, lk_rise;

    pstate_req_hold #(.CW(CW), .RW(RW), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(req_wr), .data(req_data),
        .take(take), .valid(pend_valid), .ratio(pend_ratio)
    );

    pstate_vid_lut #(.RW(RW), .VW(VW), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX),
                     .VID_BASE(VID_BASE), .VID_STEP(VID_STEP)) u_lut (
        .ratio(lut_idx), .vid(lut_vid)
    );

    pstate_rise u_vr_edge (.clk(clk), .rst_n(rst_n), .lvl(vr_ready), .rise(vr_rise));
    pstate_rise u_lk_edge (.clk(clk), .rst_n(rst_n), .lvl(pll_lock), .rise(lk_rise));

    assign take    = (state == S_IDLE) && pend_valid;
    assign start   = take && (pend_ratio != ratio_out);
    assign go_up   = pend_ratio > ratio_out;
    assign lut_idx = (state == S_IDLE) ? pend_ratio : tgt;
    assign busy    = (state != S_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = go_up ? S_RAISE_V : S_LOWER_F;
            S_RAISE_V: if (vr_rise) state_nx = S_RAISE_F;
            S_RAISE_F: if (lk_rise) state_nx = S_COMMIT;
            S_LOWER_F: if (lk_rise) state_nx = S_LOWER_V;
            S_LOWER_V: if (vr_rise) state_nx = S_COMMIT;
            S_COMMIT:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // output and target registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_out   <= VID_RST;
            ratio_out <= RW'(RATIO_MIN);
            tgt       <= RW'(RATIO_MIN);
            stat_out  <= {VID_RST, RW'(RATIO_MIN)};
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    tgt <= pend_ratio;
                    if (go_up) vid_out   <= lut_vid;
                    else       ratio_out <= pend_ratio;
                end
                S_RAISE_V: if (vr_rise) ratio_out <= tgt;
                S_LOWER_F: if (lk_rise) vid_out   <= lut_vid;
                S_COMMIT:  stat_out <= {vid_out, ratio_out};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pstate_seq_chk.sv
module pstate_seq_chk #(
    parameter int RW        = 8,
    parameter int VW        = 8,
    parameter int RATIO_MIN = 1,
    parameter int RATIO_MAX = 39,
    parameter int VID_BASE  = 40,
    parameter int VID_STEP  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vr_ready,
    input logic             pll_lock,
    input logic [VW-1:0]    vid_out,
    input logic [RW-1:0]    ratio_out,
    input logic [VW+RW-1:0] stat_out,
    input logic             busy
);
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ratio_out) >= RATIO_MIN && int'(ratio_out) <= RATIO_MAX);

    p_vid_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> int'(vid_out) == VID_BASE + VID_STEP * int'(ratio_out));

    p_stat_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_out) |-> $past(busy) && $past(vr_ready) && $past(pll_lock));

    p_stat_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> stat_out == {vid_out, ratio_out});

    p_one_knob_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_out) |-> $stable(vid_out));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(vid_out) && $stable(ratio_out)));
endmodule

bind pstate_seq pstate_seq_chk #(
    .RW(RW), .VW(VW), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX),
    .VID_BASE(VID_BASE), .VID_STEP(VID_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vr_ready(vr_ready), .pll_lock(pll_lock),
    .vid_out(vid_out), .ratio_out(ratio_out), .stat_out(stat_out), .busy(busy)
);

// File: tb/pstate_seq_bench.sv
module pstate_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_data = '0;
    logic        vr_ready, pll_lock;
    logic [7:0]  vid_out, ratio_out;
    logic [15:0] stat_out;
    logic        busy;

    int vectors = 0, misses = 0, cyc = 0;
    int vr_dly = 5, pl_dly = 7, vr_cnt, pl_cnt;
    logic [7:0]  m_vid, m_ratio, p_vid, p_ratio;
    logic [15:0] p_stat;
    logic [15:0] expq [$];

    always #2 clk = ~clk;

    pstate_seq u_pstate_seq (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_data(req_data),
        .vr_ready(vr_ready), .pll_lock(pll_lock), .vid_out(vid_out),
        .ratio_out(ratio_out), .stat_out(stat_out), .busy(busy)
    );

    function automatic logic [7:0] evid(int r);
        return 8'(40 + 3 * r);
    endfunction

    function automatic logic [15:0] estat(int r);
        return {evid(r), 8'(r)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // regulator and clock-generator models
    always @(posedge clk) begin
        if (!rst_n) begin
            vr_ready <= 1'b1; pll_lock <= 1'b1;
            m_vid <= evid(1); m_ratio <= 8'd1; vr_cnt <= 0; pl_cnt <= 0;
        end else begin
            if (vid_out != m_vid) begin
                m_vid <= vid_out; vr_ready <= 1'b0; vr_cnt <= vr_dly;
            end else if (!vr_ready) begin
                if (vr_cnt == 0) vr_ready <= 1'b1; else vr_cnt <= vr_cnt - 1;
            end
            if (ratio_out != m_ratio) begin
                m_ratio <= ratio_out; pll_lock <= 1'b0; pl_cnt <= pl_dly;
            end else if (!pll_lock) begin
                if (pl_cnt == 0) pll_lock <= 1'b1; else pl_cnt <= pl_cnt - 1;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            misses++;
            $display("FAIL watchdog (R5..R8 sequence hung): actual %0d expected <= 50000", cyc);
            finish_up();
        end
    end

    // monitor: ordering (R5, R6) and scoreboard on status (R7, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (ratio_out != p_ratio) begin
                if (ratio_out > p_ratio)
                    chk(vid_out == p_vid && vid_out == evid(int'(ratio_out)), "R5 supply before ratio", {24'd0, vid_out}, {24'd0, evid(int'(ratio_out))});
                else
                    chk(vid_out == p_vid && vid_out == evid(int'(p_ratio)), "R6 ratio before supply", {24'd0, vid_out}, {24'd0, evid(int'(p_ratio))});
            end
            if (vid_out != p_vid) begin
                if (vid_out > p_vid)
                    chk(ratio_out == p_ratio && vid_out > evid(int'(ratio_out)), "R5 ratio held during supply rise", {24'd0, ratio_out}, {24'd0, p_ratio});
                else
                    chk(ratio_out == p_ratio && vid_out == evid(int'(ratio_out)), "R6 supply drop after ratio", {24'd0, vid_out}, {24'd0, evid(int'(ratio_out))});
            end
            if (stat_out != p_stat) begin
                chk(vr_ready && pll_lock, "R7 both confirmations seen", {30'd0, vr_ready, pll_lock}, 32'd3);
                if (expq.size() == 0)
                    chk(1'b0, "R7 unexpected status update", {16'd0, stat_out}, {16'd0, p_stat});
                else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    chk(stat_out == e, "R7/R8 status value", {16'd0, stat_out}, {16'd0, e});
                end
            end
            p_ratio <= ratio_out; p_vid <= vid_out; p_stat <= stat_out;
        end else begin
            p_ratio <= ratio_out; p_vid <= vid_out; p_stat <= stat_out;
        end
    end

    task automatic write(input logic [15:0] d);
        @(negedge clk);
        req_wr = 1'b1; req_data = d;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (expq.size() != 0 || busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ratio_out == 8'd1, "R1 ratio", {24'd0, ratio_out}, 32'd1);
        chk(vid_out == 8'h2B, "R1 supply", {24'd0, vid_out}, 32'h2B);
        chk(stat_out == 16'h2B01, "R1 status", {16'd0, stat_out}, 32'h2B01);
        chk(!busy, "R1 busy", {31'd0, busy}, 32'd0);

        // R5, R4: upward step
        expq.push_back(estat(10)); write(16'h000A); settle();
        chk(stat_out == 16'h460A, "R4 supply code for ratio 10", {16'd0, stat_out}, 32'h460A);

        // R2, R6: upper byte ignored, downward step
        expq.push_back(estat(5)); write(16'hAB05); settle();
        chk(ratio_out == 8'd5, "R2 upper byte ignored", {24'd0, ratio_out}, 32'd5);

        // R3 clamping both ends
        expq.push_back(estat(39)); write(16'h00C8); settle();
        chk(stat_out == 16'h9D27, "R3 clamp high", {16'd0, stat_out}, 32'h9D27);
        expq.push_back(estat(1)); write(16'h0000); settle();
        chk(stat_out == 16'h2B01, "R3 clamp low", {16'd0, stat_out}, 32'h2B01);

        // R8 held request overwritten by a newer one
        expq.push_back(estat(20)); expq.push_back(estat(8));
        write(16'd20); repeat (3) @(negedge clk);
        chk(busy, "R8 busy during transition", {31'd0, busy}, 32'd1);
        write(16'd25); write(16'd8); settle();
        chk(stat_out == estat(8), "R8 newest request applied", {16'd0, stat_out}, {16'd0, estat(8)});

        // R9 same ratio: no transition
        write(16'd8);
        begin
            bit seen_busy = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (busy) seen_busy = 1'b1;
            end
            chk(!seen_busy, "R9 no transition for equal ratio", {31'd0, seen_busy}, 32'd0);
            chk(stat_out == estat(8), "R9 status held", {16'd0, stat_out}, {16'd0, estat(8)});
        end

        // R8 write landing in the same cycle as the final lock edge
        expq.push_back(estat(30)); expq.push_back(estat(12));
        write(16'd30);
        begin
            bit seen_low = 1'b0;
            bit hit = 1'b0;
            while (!hit) begin
                @(negedge clk);
                if (!pll_lock) seen_low = 1'b1;
                else if (seen_low) hit = 1'b1;
            end
            req_wr = 1'b1; req_data = 16'd12;
            @(negedge clk);
            req_wr = 1'b0;
        end
        settle();
        chk(stat_out == estat(12), "R8 same-cycle write applied", {16'd0, stat_out}, {16'd0, estat(12)});

        // R5 with immediate confirmations
        vr_dly = 0; pl_dly = 0;
        expq.push_back(estat(33)); write(16'd33); settle();
        chk(vid_out == evid(33), "R4 supply after fast step", {24'd0, vid_out}, {24'd0, evid(33)});

        chk(expq.size() == 0, "R8 all expected updates seen", expq.size(), 32'd0);
        finish_up();
    end
endmodule